// File: doc/BRIEF.md
# GPIO Controller with Interrupts

This block manages sixteen general-purpose pins through a small 16-bit register port. Software sets the drive direction of each pin. It changes output values through two atomic write ports, one that sets bits and one that clears bits, and it reads the output latch back. Pin inputs pass through a two-flop synchronizer before any logic uses them. Software reads these synchronized values.

Each pin can request an interrupt in one of two ways. A pin in level mode requests while its input is at a chosen polarity. A pin in edge mode requests on a rising edge, a falling edge, or both. A request sets a latched pending flag for that pin. Software clears the flag by writing ones to the clear register. A pending flag reaches the status register and the single active-high interrupt line only when that pin's mask bit is 0 and its enable bit is 1.

The register port accepts one access per cycle and never stalls, so it has no ready signal and no back-pressure. A write takes effect at the clock edge that samples it. Read data appears on the clock edge after the request and is zero in every cycle that carries no read.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, all pins are inputs (`pin_oe` = 0), outputs are 0, the mask register (0x28) reads 0xFFFF, the enable register (0x2C) reads 0, no flag is pending, and `irq` is 0.
- R2: The direction register at 0x00 is read/write. Bit n = 1 drives `pin_oe[n]` high, which makes pin n an output. Bit n = 0 makes it an input.
- R3: A write to 0x18 sets each output bit written as 1. A write to 0x1C clears each output bit written as 1. Bits written as 0 do not change. Offset 0x20 reads the output latch, and `pin_out` follows it.
- R4: Offset 0x14 reads `pin_in` after two synchronizing flops. A change presented before clock edge k is returned by a read that is sampled at edge k+2 or later.
- R5: When bit n of 0x04 is 1, pin n is level sensitive. Bit n of 0x08 picks the active level: 1 for high, 0 for low. While the input is active, the pending flag stays set, even in a cycle that writes a clear for it.
- R6: When bit n of 0x04 is 0, pin n is edge sensitive. Bit n of 0x0C enables rising edges and bit n of 0x10 enables falling edges. With both bits set, either edge sets the pending flag.
- R7: Offset 0x30 reads pending AND NOT mask (0x28) AND enable (0x2C), bit by bit.
- R8: Writing 1 to bit n of 0x34 clears pending flag n. An edge event that sets a flag in the same cycle as its clear write leaves the flag set.
- R9: `irq` is the OR of all bits of the masked status.
- R10: Reads of unmapped offsets and of the write-only offsets 0x18, 0x1C and 0x34 return 0. `bus_rdata` is 0 in every cycle after a cycle that carries no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 16 | Write data, one bit per pin |
| bus_rdata | output | 16 | Read data, valid the cycle after a read |
| pin_in | input | 16 | Raw pin input levels |
| pin_out | output | 16 | Output latch values |
| pin_oe | output | 16 | Output enables (direction) |
| irq | output | 1 | Combined interrupt, active high |

## Verification
The hardest case to reach from the ports is a clear write that lands in the same cycle as the edge event it races. That cycle lies two synchronizer stages after the pin changes. The stimulus changes the pin at a falling clock edge, lets exactly two rising edges pass, and then presents the clear write, so the event and the clear meet at the same edge. A second hard case is a level pin that remains active while it is cleared. The bench reaches it by configuring an active-low pin while its input already sits low and then writing clears over it.

// File: rtl/gpx_pkg.sv
`timescale 1ns/1ps
package gpx_pkg;
  localparam int unsigned GPX_AW = 6;

  localparam logic [GPX_AW-1:0] OFF_DIR  = 6'h00;
  localparam logic [GPX_AW-1:0] OFF_LSEL = 6'h04;
  localparam logic [GPX_AW-1:0] OFF_POL  = 6'h08;
  localparam logic [GPX_AW-1:0] OFF_REN  = 6'h0C;
  localparam logic [GPX_AW-1:0] OFF_FEN  = 6'h10;
  localparam logic [GPX_AW-1:0] OFF_DIN  = 6'h14;
  localparam logic [GPX_AW-1:0] OFF_SET  = 6'h18;
  localparam logic [GPX_AW-1:0] OFF_CLR  = 6'h1C;
  localparam logic [GPX_AW-1:0] OFF_DOUT = 6'h20;
  localparam logic [GPX_AW-1:0] OFF_MASK = 6'h28;
  localparam logic [GPX_AW-1:0] OFF_ARM  = 6'h2C;
  localparam logic [GPX_AW-1:0] OFF_STAT = 6'h30;
  localparam logic [GPX_AW-1:0] OFF_ACK  = 6'h34;
endpackage

// File: rtl/gpx_sync.sv
`timescale 1ns/1ps
module gpx_sync #(
  parameter int unsigned N      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  output logic [N-1:0] cur,
  output logic [N-1:0] prv
);
  localparam int unsigned DEPTH = STAGES + 1;

  logic [N-1:0] chain [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) chain[k] <= '0;
    end else begin
      chain[0] <= raw;
      for (int k = 1; k < DEPTH; k++) chain[k] <= chain[k-1];
    end
  end

  assign cur = chain[STAGES-1];
  assign prv = chain[STAGES];
endmodule

// File: rtl/gpx_evt.sv
`timescale 1ns/1ps
module gpx_evt #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cur,
  input  logic [N-1:0] prv,
  input  logic [N-1:0] lsel,
  input  logic [N-1:0] pol,
  input  logic [N-1:0] ren,
  input  logic [N-1:0] fen,
  input  logic [N-1:0] ack,
  output logic [N-1:0] pend
);
  logic [N-1:0] hit;

  for (genvar g = 0; g < N; g++) begin : g_pin
    logic lvl_hit;
    logic edg_hit;
    assign lvl_hit = (cur[g] == pol[g]);
    assign edg_hit = (ren[g] & cur[g] & ~prv[g]) | (fen[g] & ~cur[g] & prv[g]);
    assign hit[g]  = lsel[g] ? lvl_hit : edg_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~ack) | hit;
  end

  // R8 / R5: an event is never lost to a clear written in the same cycle
  p_event_latched_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> ((pend & $past(hit)) == $past(hit)));
endmodule

// File: rtl/gpio_irq_ctrl.sv
`timescale 1ns/1ps
module gpio_irq_ctrl
  import gpx_pkg::*;
#(
  parameter int unsigned NPIN        = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [GPX_AW-1:0] bus_addr,
  input  logic [NPIN-1:0]   bus_wdata,
  output logic [NPIN-1:0]   bus_rdata,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_oe,
  output logic              irq
);
  logic [NPIN-1:0] dir_q, lsel_q, pol_q, ren_q, fen_q;
  logic [NPIN-1:0] dout_q, mask_q, arm_q;
  logic [NPIN-1:0] cur, prv, pend, ack, status, rd_mux;
  logic            wr_en, rd_en;

  assign wr_en = bus_sel & bus_wr;
  assign rd_en = bus_sel & ~bus_wr;

  gpx_sync #(.N(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(pin_in), .cur(cur), .prv(prv)
  );

  assign ack = (wr_en && bus_addr == OFF_ACK) ? bus_wdata : '0;

  gpx_evt #(.N(NPIN)) u_evt (
    .clk(clk), .rst_n(rst_n), .cur(cur), .prv(prv),
    .lsel(lsel_q), .pol(pol_q), .ren(ren_q), .fen(fen_q),
    .ack(ack), .pend(pend)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      lsel_q <= '0;
      pol_q  <= '0;
      ren_q  <= '0;
      fen_q  <= '0;
      dout_q <= '0;
      mask_q <= '1;
      arm_q  <= '0;
    end else if (wr_en) begin
      case (bus_addr)
        OFF_DIR:  dir_q  <= bus_wdata;
        OFF_LSEL: lsel_q <= bus_wdata;
        OFF_POL:  pol_q  <= bus_wdata;
        OFF_REN:  ren_q  <= bus_wdata;
        OFF_FEN:  fen_q  <= bus_wdata;
        OFF_SET:  dout_q <= dout_q | bus_wdata;
        OFF_CLR:  dout_q <= dout_q & ~bus_wdata;
        OFF_MASK: mask_q <= bus_wdata;
        OFF_ARM:  arm_q  <= bus_wdata;
        default:  ;
      endcase
    end
  end

  assign status  = pend & ~mask_q & arm_q;
  assign irq     = |status;
  assign pin_out = dout_q;
  assign pin_oe  = dir_q;

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      OFF_DIR:  rd_mux = dir_q;
      OFF_LSEL: rd_mux = lsel_q;
      OFF_POL:  rd_mux = pol_q;
      OFF_REN:  rd_mux = ren_q;
      OFF_FEN:  rd_mux = fen_q;
      OFF_DIN:  rd_mux = cur;
      OFF_DOUT: rd_mux = dout_q;
      OFF_MASK: rd_mux = mask_q;
      OFF_ARM:  rd_mux = arm_q;
      OFF_STAT: rd_mux = status;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd_en ? rd_mux : '0;
  end

  // R3: set port raises every bit written as one
  p_set_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr == OFF_SET) |=> ((pin_out & $past(bus_wdata)) == $past(bus_wdata)));
  // R3: clear port drops every bit written as one
  p_clr_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr == OFF_CLR) |=> ((pin_out & $past(bus_wdata)) == '0));
  // R2: direction write reaches the enables next cycle
  p_dir_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr == OFF_DIR) |=> (pin_oe == $past(bus_wdata)));
  // R10: read data is idle zero after a cycle without a read
  p_rdata_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (bus_rdata == '0));
endmodule

// File: tb/sim_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_out, pin_oe;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // behavioural reference model, advanced on every rising edge
  logic [15:0] m_dir, m_lsel, m_pol, m_ren, m_fen, m_dout, m_mask, m_en, m_pend, m_rd;
  logic [15:0] seen[$];   // history of sampled pin_in, newest last

  function automatic logic [15:0] hist(int age);
    if (seen.size() > age) return seen[seen.size()-1-age];
    return 16'h0000;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_dir = 0; m_lsel = 0; m_pol = 0; m_ren = 0; m_fen = 0;
      m_dout = 0; m_mask = 16'hFFFF; m_en = 0; m_pend = 0; m_rd = 0;
      seen.delete();
    end else begin
      logic [15:0] now_v, old_v, ev, rdv, clrv;
      now_v = hist(1);
      old_v = hist(2);
      for (int i = 0; i < 16; i++) begin
        if (m_lsel[i]) ev[i] = (now_v[i] == m_pol[i]);
        else ev[i] = (m_ren[i] && now_v[i] && !old_v[i]) || (m_fen[i] && !now_v[i] && old_v[i]);
      end
      rdv = 0;
      if (bus_sel && !bus_wr) begin
        case (bus_addr)
          6'h00: rdv = m_dir;   6'h04: rdv = m_lsel;  6'h08: rdv = m_pol;
          6'h0C: rdv = m_ren;   6'h10: rdv = m_fen;   6'h14: rdv = now_v;
          6'h20: rdv = m_dout;  6'h28: rdv = m_mask;  6'h2C: rdv = m_en;
          6'h30: rdv = m_pend & ~m_mask & m_en;
          default: rdv = 0;
        endcase
      end
      clrv = (bus_sel && bus_wr && bus_addr == 6'h34) ? bus_wdata : 16'h0;
      m_pend = (m_pend & ~clrv) | ev;
      if (bus_sel && bus_wr) begin
        case (bus_addr)
          6'h00: m_dir = bus_wdata;  6'h04: m_lsel = bus_wdata;
          6'h08: m_pol = bus_wdata;  6'h0C: m_ren = bus_wdata;
          6'h10: m_fen = bus_wdata;  6'h18: m_dout = m_dout | bus_wdata;
          6'h1C: m_dout = m_dout & ~bus_wdata;
          6'h28: m_mask = bus_wdata; 6'h2C: m_en = bus_wdata;
          default: ;
        endcase
      end
      m_rd = rdv;
      seen.push_back(pin_in);
      if (seen.size() > 4) void'(seen.pop_front());
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // compare against the model every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 pin_oe", pin_oe, m_dir);
      chk("R3 pin_out", pin_out, m_dout);
      chk("R9 irq", {15'h0, irq}, {15'h0, |(m_pend & ~m_mask & m_en)});
      chk("R10 bus_rdata", bus_rdata, m_rd);
    end
  end

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] v);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    v = bus_rdata;
  endtask

  task automatic rdchk(input string tag, input logic [5:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle(4);
    rst_n = 1;
    // R1 reset state
    chk("R1 pin_oe", pin_oe, 16'h0);
    chk("R1 pin_out", pin_out, 16'h0);
    chk("R1 irq", {15'h0, irq}, 16'h0);
    rdchk("R1 mask", 6'h28, 16'hFFFF);
    rdchk("R1 enable", 6'h2C, 16'h0000);
    rdchk("R1 status", 6'h30, 16'h0000);
    // R2 direction
    wr(6'h00, 16'hF0F0);
    rdchk("R2 dir read", 6'h00, 16'hF0F0);
    chk("R2 oe", pin_oe, 16'hF0F0);
    // R3 set / clear
    wr(6'h18, 16'h0303);
    wr(6'h1C, 16'h0101);
    rdchk("R3 dout", 6'h20, 16'h0202);
    wr(6'h18, 16'h0000);
    wr(6'h1C, 16'h0000);
    rdchk("R3 zero bits", 6'h20, 16'h0202);
    chk("R3 pin_out", pin_out, 16'h0202);
    // R4 synchronized input
    pin_in = 16'hA5A5;
    idle(3);
    rdchk("R4 data in", 6'h14, 16'hA5A5);
    // R10 unmapped / write-only
    rdchk("R10 unmapped 0x24", 6'h24, 16'h0);
    rdchk("R10 unmapped 0x3C", 6'h3C, 16'h0);
    rdchk("R10 set port reads 0", 6'h18, 16'h0);
    // R6 edge modes
    pin_in = 16'h0000;
    idle(4);
    wr(6'h2C, 16'hFFFF);
    wr(6'h28, 16'h0000);
    wr(6'h0C, 16'h0014);
    wr(6'h10, 16'h0018);
    rdchk("R6 quiet", 6'h30, 16'h0000);
    pin_in = 16'h001C;
    idle(4);
    rdchk("R6 rising", 6'h30, 16'h0014);
    chk("R9 irq up", {15'h0, irq}, 16'h1);
    pin_in = 16'h0000;
    idle(4);
    rdchk("R6 falling and both", 6'h30, 16'h001C);
    wr(6'h34, 16'hFFFF);
    rdchk("R8 clear", 6'h30, 16'h0000);
    chk("R9 irq down", {15'h0, irq}, 16'h0);
    // R7 mask and enable
    wr(6'h28, 16'h0004);
    pin_in = 16'h0004;
    idle(4);
    rdchk("R7 masked", 6'h30, 16'h0000);
    chk("R7 irq masked", {15'h0, irq}, 16'h0);
    wr(6'h28, 16'h0000);
    rdchk("R7 unmasked", 6'h30, 16'h0004);
    wr(6'h2C, 16'hFFFB);
    rdchk("R7 disabled", 6'h30, 16'h0000);
    wr(6'h2C, 16'hFFFF);
    wr(6'h34, 16'hFFFF);
    // R5 level modes
    wr(6'h08, 16'h0001);
    wr(6'h04, 16'h0003);
    idle(2);
    rdchk("R5 active low", 6'h30, 16'h0002);
    wr(6'h34, 16'h0002);
    rdchk("R5 held through clear", 6'h30, 16'h0002);
    pin_in = 16'h0007;
    idle(4);
    rdchk("R5 active high", 6'h30, 16'h0003);
    wr(6'h34, 16'h0003);
    rdchk("R5 clear inactive only", 6'h30, 16'h0001);
    pin_in = 16'h0006;
    idle(4);
    wr(6'h34, 16'h0001);
    rdchk("R5 released", 6'h30, 16'h0000);
    // R8 edge coinciding with clear
    pin_in = 16'h0002;
    idle(4);
    wr(6'h34, 16'hFFFF);
    rdchk("R8 clean", 6'h30, 16'h0000);
    @(negedge clk) pin_in = 16'h0006;
    @(negedge clk);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 6'h34; bus_wdata = 16'hFFFF;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    rdchk("R8 edge beats clear", 6'h30, 16'h0004);
    idle(2);
    finish_run();
  end
endmodule